// File: doc/BRIEF.md
# Reset Manager with Source Capture

This block gathers the reset requests of a small microcontroller and turns them into two reset domains. A cold reset comes only from power-on. A system reset is raised by power-on, by the external reset pad, by a Port A pattern match, and by watchdog expiry and bus errors when software has enabled those two sources. A system reset lasts for a fixed number of clock cycles after the last request, then ends on a clock edge. A third output, the peripheral-configuration reset, follows the system reset only when its enable bit is set.

Software reaches the block through two 8-bit registers on a simple select/write-enable bus. The control register holds the source enables and the sleep enable. The status register records which source caused a reset, using a separate flag for a pad reset that arrives during sleep. Each status flag clears when the register is read. Writing bit 7 of the status register asks for sleep. The sleep request stays active until the next system reset, and the external clock and power logic acts on it.

Top module: `rst_mgr`

## Requirements
- R1: `cold_rst_o` is 1 while `rst_ni` is low and stays 1 until the first rising clock edge after `rst_ni` goes high. After that it is 0. No other input drives it.
- R2: A reset request is `pad_rst_i` or `porta_match_i` high at a clock edge, or an enabled watchdog or bus-error source high at a clock edge. `sys_rst_o` goes to 1 at that edge and stays 1 until STRETCH (default 16) edges have passed with no request. After power-on it is also held for STRETCH edges following the release of `rst_ni`.
- R3: `wdt_expire_i` makes a reset request and sets its status flag only while control bit 4 is 1. `bus_err_i` does the same only while control bit 5 is 1.
- R4: The control register is at address 0. Bit 7 is the sleep enable, bit 6 the peripheral-configuration reset enable, bit 5 the bus-error enable and bit 4 the watchdog enable. Bits 3..0 read 0. All bits reset to 0 on cold reset only, and a system reset leaves them unchanged.
- R5: Control bit 4 is set by writing 1 to it. A write of 0 to bit 4 has no effect, so once set it stays set until cold reset.
- R6: `pconf_rst_o` is `sys_rst_o` when control bit 6 is 1, and 0 otherwise.
- R7: The status register is at address 1. Bit 5 flags bus error, bit 4 watchdog, bit 3 Port A match, bit 2 reset pad and bit 1 reset pad while asleep. Bits 7, 6 and 0 read 0. `bus_rdata_o` shows the register chosen by `bus_addr_i` in the same cycle.
- R8: A read of address 1 (`bus_sel_i`=1, `bus_we_i`=0) clears all status flags at that clock edge. If a cause arrives at the same edge, its flag is set anyway. Flags are otherwise cleared only by cold reset.
- R9: A write to address 1 with data bit 7 set raises `sleep_o` at that edge, but only if control bit 7 was already 1. With control bit 7 at 0 the write has no effect. Any system reset, including one that starts at that edge, clears `sleep_o`.
- R10: A pad reset while `sleep_o` is 1 sets status bit 1 and leaves bit 2 clear. While `sleep_o` is 0, a pad reset sets bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| pad_rst_i | input | 1 | External reset pad, active high, already synchronized |
| porta_match_i | input | 1 | Port A combination match |
| wdt_expire_i | input | 1 | Watchdog timeout |
| bus_err_i | input | 1 | Bus-error strobe |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write enable (0 = read) |
| bus_addr_i | input | 1 | Register address: 0 control, 1 status |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| cold_rst_o | output | 1 | Cold reset |
| sys_rst_o | output | 1 | System-wide reset |
| pconf_rst_o | output | 1 | Peripheral-configuration reset |
| sleep_o | output | 1 | Sleep request to clock and power control |

## Verification
Every cycle, the assertions check these properties: a request raises the system reset on the next edge; the peripheral-configuration and cold resets never appear without the system reset; the watchdog enable never falls; a flag set by a cause survives a clearing read at the same edge; a system reset removes sleep; and a pad event during sleep lands in the sleep flag. Other behaviour only the bench scenarios can show. This covers the exact length of the reset stretch and its restart when requests overlap. It also covers the fact that enables and flags survive a system reset but not power-on, and the value read back from each register after writes and reads are interleaved with reset sources. The bench compares all of these against a cycle model built from the requirements.

// File: rtl/rst_mgr_pkg.sv
package rst_mgr_pkg;
  localparam int DW = 8;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // control bit positions
  localparam int C_SLEEP_EN = 7;
  localparam int C_PCONF_EN = 6;
  localparam int C_BERR_EN  = 5;
  localparam int C_WD_EN    = 4;
  localparam int C_LSB      = 4;

  // status bit positions
  localparam int S_SLEEP_CMD = 7;

  typedef struct packed {
    logic berr;
    logic wd;
    logic porta;
    logic pad;
    logic pad_slp;
  } cause_t;
endpackage

// File: rtl/rst_ctrl_reg.sv
module rst_ctrl_reg
  import rst_mgr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [DW-1:C_LSB]   wdata_i,
  output logic [DW-1:0]       ctrl_o
);
  logic [DW-1:C_LSB] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (we_i) begin
      q                  <= wdata_i;
      q[C_WD_EN]         <= q[C_WD_EN] | wdata_i[C_WD_EN]; // set-only
    end
  end

  assign ctrl_o = {q, {C_LSB{1'b0}}};
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_mgr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  cause_t set_i,
  output cause_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= cause_t'((clr_i ? '0 : q_o) | set_i); // set wins
  end
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic active_o
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= LOAD;
    else if (hit_i)       cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign active_o = (cnt != '0);
endmodule

// File: rtl/rst_mgr.sv
module rst_mgr
  import rst_mgr_pkg::*;
#(
  parameter int STRETCH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pad_rst_i,
  input  logic          porta_match_i,
  input  logic          wdt_expire_i,
  input  logic          bus_err_i,
  input  logic          bus_sel_i,
  input  logic          bus_we_i,
  input  logic          bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          cold_rst_o,
  output logic          sys_rst_o,
  output logic          pconf_rst_o,
  output logic          sleep_o
);
  logic [DW-1:0] ctrl_q;
  cause_t        stat_q, cause_set;
  logic          cold_q, sleep_q;
  logic          wd_hit, be_hit, src_hit;
  logic          ctrl_wr, stat_wr, stat_rd;
  logic          unused_wdata;

  assign ctrl_wr = bus_sel_i &  bus_we_i & (bus_addr_i == ADDR_CTRL);
  assign stat_wr = bus_sel_i &  bus_we_i & (bus_addr_i == ADDR_STAT);
  assign stat_rd = bus_sel_i & ~bus_we_i & (bus_addr_i == ADDR_STAT);
  assign unused_wdata = ^bus_wdata_i[C_LSB-1:0];

  assign wd_hit  = wdt_expire_i & ctrl_q[C_WD_EN];
  assign be_hit  = bus_err_i    & ctrl_q[C_BERR_EN];
  assign src_hit = pad_rst_i | porta_match_i | wd_hit | be_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cold_q <= 1'b1;
    else         cold_q <= 1'b0;
  end

  rst_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_wr),
    .wdata_i (bus_wdata_i[DW-1:C_LSB]),
    .ctrl_o  (ctrl_q)
  );

  always_comb begin
    cause_set         = '0;
    cause_set.berr    = be_hit;
    cause_set.wd      = wd_hit;
    cause_set.porta   = porta_match_i;
    cause_set.pad     = pad_rst_i & ~sleep_q;
    cause_set.pad_slp = pad_rst_i &  sleep_q;
  end

  rst_cause_reg u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (stat_rd),
    .set_i  (cause_set),
    .q_o    (stat_q)
  );

  rst_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (src_hit),
    .active_o (sys_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   sleep_q <= 1'b0;
    else if (src_hit || sys_rst_o) sleep_q <= 1'b0;
    else if (stat_wr && bus_wdata_i[S_SLEEP_CMD] && ctrl_q[C_SLEEP_EN])
                                   sleep_q <= 1'b1;
  end

  assign bus_rdata_o = (bus_addr_i == ADDR_CTRL) ? ctrl_q
                     : {2'b00, stat_q, 1'b0};
  assign cold_rst_o  = cold_q;
  assign pconf_rst_o = sys_rst_o & ctrl_q[C_PCONF_EN];
  assign sleep_o     = sleep_q;
endmodule

// File: rtl/rst_mgr_chk.sv
module rst_mgr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pad_rst_i,
  input logic       porta_match_i,
  input logic       wdt_expire_i,
  input logic       bus_addr_i,
  input logic [7:0] bus_rdata_o,
  input logic       cold_rst_o,
  input logic       sys_rst_o,
  input logic       pconf_rst_o,
  input logic       sleep_o,
  input logic       src_hit,
  input logic       stat_rd,
  input logic [7:0] ctrl_q,
  input logic [4:0] stat_q
);
  p_cold_in_sys_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_rst_o |-> sys_rst_o);

  p_req_raises_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_hit |=> sys_rst_o);

  p_wd_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[3]) |-> $past(wdt_expire_i && ctrl_q[4]));

  p_wd_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_q[4]) |-> ctrl_q[4]);

  p_pconf_in_sys_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pconf_rst_o |-> sys_rst_o);

  p_stat_spare_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i |-> (bus_rdata_o[7:6] == 2'b00 && bus_rdata_o[0] == 1'b0));

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && porta_match_i) |=> stat_q[2]);

  p_sleep_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sleep_o);

  p_sleep_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(ctrl_q[7]));

  p_pad_sleep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_rst_i && sleep_o) |=> stat_q[0]);
endmodule

bind rst_mgr rst_mgr_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pad_rst_i     (pad_rst_i),
  .porta_match_i (porta_match_i),
  .wdt_expire_i  (wdt_expire_i),
  .bus_addr_i    (bus_addr_i),
  .bus_rdata_o   (bus_rdata_o),
  .cold_rst_o    (cold_rst_o),
  .sys_rst_o     (sys_rst_o),
  .pconf_rst_o   (pconf_rst_o),
  .sleep_o       (sleep_o),
  .src_hit       (src_hit),
  .stat_rd       (stat_rd),
  .ctrl_q        (ctrl_q),
  .stat_q        (stat_q)
);

// File: tb/rst_mgr_bench.sv
module rst_mgr_bench;
  localparam int STRETCH = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pad_rst_i = 0, porta_match_i = 0, wdt_expire_i = 0, bus_err_i = 0;
  logic       bus_sel_i = 0, bus_we_i = 0, bus_addr_i = 0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       cold_rst_o, sys_rst_o, pconf_rst_o, sleep_o;

  int n_chk = 0, n_bad = 0;

  // model state
  logic       m_cold, m_sleep;
  int         m_cnt;
  logic [7:0] m_ctrl, m_stat;

  always #2 clk_i = ~clk_i; // 4 ns period, 250 MHz

  rst_mgr #(.STRETCH(STRETCH)) u_rst_mgr (
    .clk_i, .rst_ni, .pad_rst_i, .porta_match_i, .wdt_expire_i, .bus_err_i,
    .bus_sel_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .cold_rst_o, .sys_rst_o, .pconf_rst_o, .sleep_o
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic a);
    return a ? {2'b00, m_stat[5:1], 1'b0} : {m_ctrl[7:4], 4'h0};
  endfunction

  task automatic model_reset();
    m_cold = 1; m_cnt = STRETCH; m_ctrl = '0; m_stat = '0; m_sleep = 0;
  endtask

  task automatic model_tick();
    logic trig, rd, wr;
    trig = pad_rst_i | porta_match_i | (wdt_expire_i & m_ctrl[4]) | (bus_err_i & m_ctrl[5]);
    rd = bus_sel_i & ~bus_we_i;
    wr = bus_sel_i & bus_we_i;
    if (trig || m_cnt != 0) m_sleep = 0;
    else if (wr && bus_addr_i && bus_wdata_i[7] && m_ctrl[7]) m_sleep = 1;
    if (rd && bus_addr_i) m_stat = '0;
    if (bus_err_i && m_ctrl[5]) m_stat[5] = 1;
    if (wdt_expire_i && m_ctrl[4]) m_stat[4] = 1;
    if (porta_match_i) m_stat[3] = 1;
    if (pad_rst_i) begin
      if (sleep_o_model_prev) m_stat[1] = 1; else m_stat[2] = 1;
    end
    if (wr && !bus_addr_i) m_ctrl = {bus_wdata_i[7:5], m_ctrl[4] | bus_wdata_i[4], 4'h0};
    m_cnt  = trig ? STRETCH : (m_cnt != 0 ? m_cnt - 1 : 0);
    m_cold = 0;
  endtask

  // sleep state seen by the pad event is the value before this edge
  logic sleep_o_model_prev;

  task automatic start(input logic pad, porta, wdt, berr, sel, we, addr,
                       input logic [7:0] wd);
    @(negedge clk_i);
    chk(cold_rst_o, m_cold, "R1 cold_rst_o");
    chk(sys_rst_o, m_cnt != 0, "R2 sys_rst_o");
    chk(pconf_rst_o, (m_cnt != 0) & m_ctrl[6], "R6 pconf_rst_o");
    chk(sleep_o, m_sleep, "R9 sleep_o");
    pad_rst_i = pad; porta_match_i = porta; wdt_expire_i = wdt; bus_err_i = berr;
    bus_sel_i = sel; bus_we_i = we; bus_addr_i = addr; bus_wdata_i = wd;
    #1;
    chk(bus_rdata_o, exp_rd(addr), addr ? "R7 status read" : "R4 control read");
  endtask

  task automatic fin();
    @(posedge clk_i);
    sleep_o_model_prev = m_sleep;
    model_tick();
    #1;
  endtask

  task automatic step(input logic pad, porta, wdt, berr, sel, we, addr,
                      input logic [7:0] wd);
    start(pad, porta, wdt, berr, sel, we, addr, wd);
    fin();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    step(0, 0, 0, 0, 1, 1, a, d);
  endtask

  task automatic peek(input logic a, input logic [7:0] exp, input string tag);
    start(0, 0, 0, 0, 0, 0, a, 8'h00);
    chk(bus_rdata_o, exp, tag);
    fin();
  endtask

  task automatic por();
    @(negedge clk_i);
    rst_ni = 0;
    pad_rst_i = 0; porta_match_i = 0; wdt_expire_i = 0; bus_err_i = 0;
    bus_sel_i = 0; bus_we_i = 0;
    model_reset();
    #1;
    chk(cold_rst_o, 1'b1, "R1 cold during por");
    chk(sys_rst_o, 1'b1, "R2 sys during por");
    chk(sleep_o, 1'b0, "R9 sleep during por");
    @(negedge clk_i);
    rst_ni = 1;
    fin();
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    model_reset();
    sleep_o_model_prev = 0;
    por();
    chk(cold_rst_o, 1'b0, "R1 cold after first edge");
    idle(STRETCH + 2);

    // R3: watchdog disabled
    step(0, 0, 1, 0, 0, 0, 0, 8'h00);
    chk(sys_rst_o, 1'b0, "R3 wdt ignored when disabled");
    peek(1, 8'h00, "R3 no wd flag when disabled");

    // R5: watchdog enable is set-only
    wr(0, 8'h10);
    wr(0, 8'h00);
    peek(0, 8'h10, "R5 wd enable sticky");
    wr(0, 8'h3F);
    peek(0, 8'h30, "R4 control low bits read 0");

    // R8: set beats clear
    step(0, 1, 0, 0, 1, 0, 1, 8'h00);
    peek(1, 8'h08, "R8 set wins over read clear");
    idle(STRETCH + 2);
    step(0, 0, 0, 0, 1, 0, 1, 8'h00);
    peek(1, 8'h00, "R8 read clears flags");

    // R9: sleep gated by enable
    wr(1, 8'h80);
    chk(sleep_o, 1'b0, "R9 sleep ignored when disabled");
    wr(0, 8'hB0);
    wr(1, 8'h80);
    chk(sleep_o, 1'b1, "R9 sleep taken when enabled");

    // R10: pad during sleep
    step(1, 0, 0, 0, 0, 0, 0, 8'h00);
    chk(sys_rst_o, 1'b1, "R2 pad raises sys reset");
    chk(sleep_o, 1'b0, "R9 sys reset clears sleep");
    peek(1, 8'h02, "R10 pad in sleep flag");
    idle(STRETCH + 2);
    peek(0, 8'hB0, "R9 control kept over sys reset");
    step(0, 0, 0, 0, 1, 0, 1, 8'h00);

    // R6: peripheral config reset
    wr(0, 8'h70);
    step(0, 0, 0, 1, 0, 0, 0, 8'h00);
    chk(pconf_rst_o, 1'b1, "R6 pconf follows sys reset");
    chk(sys_rst_o, 1'b1, "R3 enabled bus error resets");
    idle(STRETCH + 2);
    peek(1, 8'h20, "R3 bus error flag");
    step(0, 0, 0, 0, 1, 0, 1, 8'h00);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (i == 2000) begin
        por();
        peek(0, 8'h00, "R4 control cleared by cold reset");
      end
      step(($urandom % 97) == 0, ($urandom % 113) == 0,
           ($urandom % 61) == 0, ($urandom % 67) == 0,
           ($urandom % 3) != 0, $urandom % 2, $urandom % 2, 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule